// File: doc/BRIEF.md
# Routed GPIO Interrupt Detector

This block turns the synchronized levels of a set of GPIO pads into interrupt events and funnels them onto sixteen shared interrupt lines. Each pad carries its own trigger code, a receive-invert control and a 4-bit line selector. A pad whose trigger condition is met sets the status bit of the line it selects, and any number of pads may point at the same line. Software reads the status word, acknowledges events by writing ones to it, and enables or disables individual lines through a mask word. A single summary output tells the interrupt controller that at least one enabled line is pending.

The pad configuration storage is outside this block: the trigger codes, invert bits and line selectors arrive as flat input vectors. A small 32-bit register port with a combinational read path exposes the status word (offset 0x300) and the mask word (offset 0x380). Each pad's detector keeps one register holding the previous effective level. Trigger codes are decoded into a named set of modes (off, falling, rising, both, level). There is no sequencing state machine. Its only per-pad transition is the effective-level sample taken on every clock.

Top module: `gpio_irq_router`

## Requirements
- R1: After reset the status word and the mask word read as zero and the summary output is low. The previous effective level of every pad is taken as low.
- R2: Trigger code 2 (rising) sets the selected line's status bit on the clock edge at which the pad's effective level is high and its previous sample was low.
- R3: Trigger code 1 (falling) sets the selected line's status bit on the clock edge at which the effective level is low and its previous sample was high.
- R4: Trigger code 3 (both) sets the status bit on any change of the effective level between consecutive samples.
- R5: Trigger code 4 (level) sets the status bit on every clock edge at which the effective level is high, so a clear does not stick while the level persists.
- R6: When a pad's invert bit is 1, its effective level is the complement of the pad input before detection, which makes code 4 an active-low trigger.
- R7: Trigger codes 0, 5, 6 and 7 never set any status bit.
- R8: The line selector value n (0 to 15) routes a pad to status bit n. Detections from several pads selecting the same line are ORed together.
- R9: A write to offset 0x300 clears each status bit whose data bit (bits 15:0) is 1 and leaves the others unchanged. Writing 0xFFFF clears every line.
- R10: If a detection and a clear hit the same status bit in the same cycle, the bit ends up set.
- R11: A write to offset 0x380 loads bits 15:0 into the mask word, where 1 enables a line. Reads at 0x300 and 0x380 return the status and mask words in bits 15:0 with zeros above, and reads at any other offset return zero.
- R12: The summary output is high exactly when the bitwise AND of status and mask is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pad_level_i | input | NUM_PADS | Synchronized pad levels, one bit per pad |
| pad_mode_i | input | 3*NUM_PADS | Trigger code per pad, pad p at bits 3p+2:3p |
| pad_inv_i | input | NUM_PADS | Receive-invert control per pad |
| pad_line_i | input | 4*NUM_PADS | Line selector per pad, pad p at bits 4p+3:4p |
| reg_addr_i | input | ADDR_W | Register byte offset |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Combinational read data |
| irq_o | output | 1 | Summary interrupt |

## Verification
The bench sweeps all eight trigger codes with both invert settings over a level pattern that contains rises, falls and held levels. A decoder that mixed up falling and rising, or that let a reserved code through, would then set a status bit in the wrong cycle or where none is due. It drives simultaneous edges from pads that share a line, so a router that kept only one pad per line would be caught. It also writes partial clear patterns, which exposes a clear that wipes whole words. A clear issued while a level trigger is still active would leave the bit at zero in a design where clear beats set. Finally, a sweep of mask values against a fixed status word exposes a summary output that ignores the mask or uses OR instead of AND.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    typedef enum logic [2:0] {
        TRIG_OFF   = 3'd0,
        TRIG_FALL  = 3'd1,
        TRIG_RISE  = 3'd2,
        TRIG_BOTH  = 3'd3,
        TRIG_LEVEL = 3'd4
    } trig_mode_e;

    localparam int MODE_W    = 3;
    localparam int DATA_W    = 32;

endpackage

// File: rtl/gpio_irq_pad_detect.sv
module gpio_irq_pad_detect
    import gpio_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              level_i,
    input  logic              inv_i,
    input  logic [MODE_W-1:0] mode_i,
    output logic              hit_o
);

    logic eff_lvl;
    logic prev_lvl;

    assign eff_lvl = level_i ^ inv_i;

    // previous effective level sample
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_lvl <= 1'b0;
        end else begin
            prev_lvl <= eff_lvl;
        end
    end

    // trigger decode
    always_comb begin
        unique case (mode_i)
            TRIG_FALL:  hit_o = prev_lvl & ~eff_lvl;
            TRIG_RISE:  hit_o = eff_lvl & ~prev_lvl;
            TRIG_BOTH:  hit_o = eff_lvl ^ prev_lvl;
            TRIG_LEVEL: hit_o = eff_lvl;
            default:    hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/gpio_irq_line_router.sv
module gpio_irq_line_router #(
    parameter int NUM_PADS   = 8,
    parameter int LINE_SEL_W = 4,
    localparam int NUM_LINES = 1 << LINE_SEL_W
) (
    input  logic [NUM_PADS-1:0]            pad_hit_i,
    input  logic [NUM_PADS*LINE_SEL_W-1:0] pad_line_i,
    output logic [NUM_LINES-1:0]           line_hit_o
);

    for (genvar ln = 0; ln < NUM_LINES; ln++) begin : g_line
        always_comb begin
            line_hit_o[ln] = 1'b0;
            for (int p = 0; p < NUM_PADS; p++) begin
                if (pad_hit_i[p] &&
                    (pad_line_i[p*LINE_SEL_W +: LINE_SEL_W] == LINE_SEL_W'(ln))) begin
                    line_hit_o[ln] = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/gpio_irq_status_regs.sv
module gpio_irq_status_regs
    import gpio_irq_pkg::*;
#(
    parameter int NUM_LINES  = 16,
    parameter int ADDR_W     = 12,
    parameter logic [ADDR_W-1:0] STATUS_OFS = 12'h300,
    parameter logic [ADDR_W-1:0] MASK_OFS   = 12'h380
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_hit_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic                 reg_wr_i,
    input  logic [DATA_W-1:0]    reg_wdata_i,
    output logic [DATA_W-1:0]    reg_rdata_o,
    output logic [NUM_LINES-1:0] status_o,
    output logic [NUM_LINES-1:0] mask_o
);

    logic                 sel_status;
    logic                 sel_mask;
    logic [NUM_LINES-1:0] clr_vec;
    logic                 unused_wdata_hi;

    assign sel_status      = (reg_addr_i == STATUS_OFS);
    assign sel_mask        = (reg_addr_i == MASK_OFS);
    assign clr_vec         = (reg_wr_i && sel_status) ? reg_wdata_i[NUM_LINES-1:0] : '0;
    assign unused_wdata_hi = ^reg_wdata_i[DATA_W-1:NUM_LINES];

    // status: write-one-to-clear, detection wins
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            status_o <= '0;
        end else begin
            status_o <= (status_o & ~clr_vec) | line_hit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_o <= '0;
        end else if (reg_wr_i && sel_mask) begin
            mask_o <= reg_wdata_i[NUM_LINES-1:0];
        end
    end

    always_comb begin
        reg_rdata_o = '0;
        if (sel_status) begin
            reg_rdata_o[NUM_LINES-1:0] = status_o;
        end else if (sel_mask) begin
            reg_rdata_o[NUM_LINES-1:0] = mask_o;
        end
    end

endmodule

// File: rtl/gpio_irq_router.sv
module gpio_irq_router
    import gpio_irq_pkg::*;
#(
    parameter int NUM_PADS   = 8,
    parameter int LINE_SEL_W = 4,
    parameter int ADDR_W     = 12,
    localparam int NUM_LINES = 1 << LINE_SEL_W
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [NUM_PADS-1:0]            pad_level_i,
    input  logic [NUM_PADS*MODE_W-1:0]     pad_mode_i,
    input  logic [NUM_PADS-1:0]            pad_inv_i,
    input  logic [NUM_PADS*LINE_SEL_W-1:0] pad_line_i,
    input  logic [ADDR_W-1:0]              reg_addr_i,
    input  logic                           reg_wr_i,
    input  logic [DATA_W-1:0]              reg_wdata_i,
    output logic [DATA_W-1:0]              reg_rdata_o,
    output logic                           irq_o
);

    logic [NUM_PADS-1:0]  pad_hit;
    logic [NUM_LINES-1:0] line_hit;
    logic [NUM_LINES-1:0] status_q;
    logic [NUM_LINES-1:0] mask_q;

    for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
        gpio_irq_pad_detect u_det (
            .clk     (clk),
            .rst_n   (rst_n),
            .level_i (pad_level_i[p]),
            .inv_i   (pad_inv_i[p]),
            .mode_i  (pad_mode_i[p*MODE_W +: MODE_W]),
            .hit_o   (pad_hit[p])
        );
    end

    gpio_irq_line_router #(
        .NUM_PADS   (NUM_PADS),
        .LINE_SEL_W (LINE_SEL_W)
    ) u_route (
        .pad_hit_i  (pad_hit),
        .pad_line_i (pad_line_i),
        .line_hit_o (line_hit)
    );

    gpio_irq_status_regs #(
        .NUM_LINES (NUM_LINES),
        .ADDR_W    (ADDR_W),
        .STATUS_OFS(ADDR_W'(12'h300)),
        .MASK_OFS  (ADDR_W'(12'h380))
    ) u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .line_hit_i  (line_hit),
        .reg_addr_i  (reg_addr_i),
        .reg_wr_i    (reg_wr_i),
        .reg_wdata_i (reg_wdata_i),
        .reg_rdata_o (reg_rdata_o),
        .status_o    (status_q),
        .mask_o      (mask_q)
    );

    assign irq_o = |(status_q & mask_q);

endmodule

// File: rtl/gpio_irq_router_chk.sv
module gpio_irq_router_chk #(
    parameter int NUM_LINES = 16,
    parameter int ADDR_W    = 12
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 reg_wr_i,
    input logic [ADDR_W-1:0]    reg_addr_i,
    input logic [31:0]          reg_wdata_i,
    input logic [NUM_LINES-1:0] line_hit,
    input logic [NUM_LINES-1:0] status_q,
    input logic [NUM_LINES-1:0] mask_q,
    input logic                 irq_o
);

    logic                 wr_status;
    logic                 wr_mask;
    logic [NUM_LINES-1:0] clr_bits;

    assign wr_status = reg_wr_i && (reg_addr_i == ADDR_W'(12'h300));
    assign wr_mask   = reg_wr_i && (reg_addr_i == ADDR_W'(12'h380));
    assign clr_bits  = wr_status ? reg_wdata_i[NUM_LINES-1:0] : '0;

    a_r1_reset_clean: assert property (@(posedge clk)
        $rose(rst_n) |-> (status_q == '0 && mask_q == '0 && !irq_o));

    a_r9_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        wr_status |=> ((status_q & $past(clr_bits) & ~$past(line_hit)) == '0));

    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (line_hit != '0) |=> ((status_q & $past(line_hit)) == $past(line_hit)));

    a_r8_no_stray_set: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((status_q & ~$past(status_q) & ~$past(line_hit)) == '0));

    a_r11_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask |=> $stable(mask_q));

    a_r12_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq_o);

endmodule

bind gpio_irq_router gpio_irq_router_chk #(
    .NUM_LINES (NUM_LINES),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .line_hit    (line_hit),
    .status_q    (status_q),
    .mask_q      (mask_q),
    .irq_o       (irq_o)
);

// File: tb/gpio_irq_router_tb_top.sv
`timescale 1ns/100ps
module gpio_irq_router_tb_top;

    localparam int NP = 4;
    localparam logic [11:0] A_STAT = 12'h300;
    localparam logic [11:0] A_MASK = 12'h380;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0]   pad_level_i = '0;
    logic [NP*3-1:0] pad_mode_i  = '0;
    logic [NP-1:0]   pad_inv_i   = '0;
    logic [NP*4-1:0] pad_line_i  = '0;
    logic [11:0]   reg_addr_i  = '0;
    logic          reg_wr_i    = 1'b0;
    logic [31:0]   reg_wdata_i = '0;
    logic [31:0]   reg_rdata_o;
    logic          irq_o;

    int checks = 0;
    int errors = 0;
    logic [15:0] exp_stat = '0;
    logic [15:0] exp_mask = '0;
    logic [NP-1:0] prev_eff = '0;

    always #2 clk = ~clk;

    gpio_irq_router #(.NUM_PADS(NP), .LINE_SEL_W(4), .ADDR_W(12)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .pad_level_i(pad_level_i), .pad_mode_i(pad_mode_i),
        .pad_inv_i(pad_inv_i), .pad_line_i(pad_line_i),
        .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i),
        .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o),
        .irq_o(irq_o)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int p, input int mode, input bit inv, input int line);
        pad_mode_i[p*3 +: 3] = 3'(mode);
        pad_inv_i[p]         = inv;
        pad_line_i[p*4 +: 4] = 4'(line);
    endtask

    task automatic observe(input string tag);
        reg_wr_i   = 1'b0;
        reg_addr_i = A_STAT;
        #0.3;
        chk(tag, reg_rdata_o, {16'h0, exp_stat});
        reg_addr_i = A_MASK;
        #0.3;
        chk("R11 mask readback", reg_rdata_o, {16'h0, exp_mask});
        chk("R12 summary", {31'h0, irq_o}, {31'h0, |(exp_stat & exp_mask)});
    endtask

    // one clock: drive, predict, then observe after the edge
    task automatic step(input string tag, input bit wr, input logic [11:0] a, input logic [31:0] d);
        logic [15:0] set_v;
        logic [15:0] clr_v;
        @(negedge clk);
        reg_wr_i = wr; reg_addr_i = a; reg_wdata_i = d;
        set_v = '0;
        for (int p = 0; p < NP; p++) begin
            bit e, pv, h;
            e  = pad_level_i[p] ^ pad_inv_i[p];
            pv = prev_eff[p];
            case (pad_mode_i[p*3 +: 3])
                3'd1: h = pv & ~e;
                3'd2: h = e & ~pv;
                3'd3: h = e ^ pv;
                3'd4: h = e;
                default: h = 1'b0;
            endcase
            if (h) set_v[pad_line_i[p*4 +: 4]] = 1'b1;
            prev_eff[p] = e;
        end
        clr_v = (wr && a == A_STAT) ? d[15:0] : 16'h0;
        exp_stat = (exp_stat & ~clr_v) | set_v;
        if (wr && a == A_MASK) exp_mask = d[15:0];
        @(posedge clk);
        #1;
        observe(tag);
    endtask

    task automatic idle_all();
        for (int p = 0; p < NP; p++) cfg(p, 0, 1'b0, 0);
        pad_level_i = '0;
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        observe("R1 reset status");
        reg_addr_i = 12'h004;
        #0.3;
        chk("R11 unmapped read", reg_rdata_o, 32'h0);

        step("R11 mask all", 1'b1, A_MASK, 32'hFFFF_FFFF);

        // trigger-code and invert sweep
        for (int m = 0; m < 8; m++) begin
            for (int iv = 0; iv < 2; iv++) begin
                string tg;
                int pd;
                int ln;
                case (m)
                    1: tg = "R3 falling";
                    2: tg = "R2 rising";
                    3: tg = "R4 both";
                    4: tg = "R5 level";
                    default: tg = "R7 disabled code";
                endcase
                if (iv == 1) tg = {tg, " R6 inverted"};
                pd = m % NP;
                ln = (m * 3 + iv * 5) % 16;
                idle_all();
                step(tg, 1'b1, A_STAT, 32'hFFFF);
                cfg(pd, m, iv[0], ln);
                pad_level_i[pd] = 1'b0; step(tg, 1'b0, A_STAT, 0);
                pad_level_i[pd] = 1'b1; step(tg, 1'b0, A_STAT, 0);
                pad_level_i[pd] = 1'b1; step(tg, 1'b0, A_STAT, 0);
                step(tg, 1'b1, A_STAT, 32'hFFFF);
                pad_level_i[pd] = 1'b0; step(tg, 1'b0, A_STAT, 0);
                pad_level_i[pd] = 1'b0; step(tg, 1'b1, A_STAT, 32'hFFFF);
                pad_level_i[pd] = 1'b1; step(tg, 1'b0, A_STAT, 0);
            end
        end

        // shared line OR-merge
        idle_all();
        for (int p = 0; p < NP; p++) cfg(p, 2, 1'b0, 9);
        cfg(1, 2, 1'b0, 2);
        step("R8 setup", 1'b1, A_STAT, 32'hFFFF);
        pad_level_i[2] = 1'b1; step("R8 single pad", 1'b0, A_STAT, 0);
        step("R8 clear", 1'b1, A_STAT, 32'hFFFF);
        pad_level_i[0] = 1'b1; pad_level_i[3] = 1'b1; step("R8 two pads", 1'b0, A_STAT, 0);
        pad_level_i[1] = 1'b1; step("R8 other line", 1'b0, A_STAT, 0);

        // partial write-one-to-clear
        idle_all();
        cfg(0, 2, 1'b0, 1); cfg(1, 2, 1'b0, 4); cfg(2, 2, 1'b0, 7); cfg(3, 2, 1'b0, 12);
        step("R9 setup", 1'b1, A_STAT, 32'hFFFF);
        pad_level_i = '1; step("R9 set four", 1'b0, A_STAT, 0);
        step("R9 partial clear", 1'b1, A_STAT, 32'h0000_0012);
        step("R9 zero write", 1'b1, A_STAT, 32'h0);
        step("R9 full clear", 1'b1, A_STAT, 32'hFFFF);

        // set versus clear in the same cycle
        idle_all();
        cfg(0, 4, 1'b0, 5); cfg(1, 2, 1'b0, 11);
        pad_level_i[0] = 1'b1;
        step("R10 level set", 1'b0, A_STAT, 0);
        step("R10 clear collides", 1'b1, A_STAT, 32'h0000_0020);
        pad_level_i[1] = 1'b1;
        step("R10 edge collides", 1'b1, A_STAT, 32'h0000_0800);

        // mask sweep against a fixed status word
        for (int k = 0; k < 16; k++) begin
            step("R12 mask sweep", 1'b1, A_MASK, 32'(16'h1 << k));
        end
        step("R12 mask off", 1'b1, A_MASK, 32'h0);
        step("R12 mask complement", 1'b1, A_MASK, 32'h0000_F7DF);
        step("R11 upper bits", 1'b1, A_MASK, 32'hABCD_0820);
        reg_addr_i = 12'h100;
        #0.3;
        chk("R11 unmapped read", reg_rdata_o, 32'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule